// File: doc/BRIEF.md
# Escalating Watchdog Controller

This block watches a chosen periodic tick and escalates when software stops servicing it. Several timer expiry pulses come in on a small vector, and a configuration field picks which one counts. While the watchdog is running, each counted expiry advances a stage counter. The first expiry flags an interrupt. The second raises a fast interrupt. At the final stage the block latches a system reset request and a power-controller reset request. Each output has its own enable bit.

Software uses a four-word register bank: configuration, status, command and key. A start command is also the keep-alive: it clears the stage counter, so escalation begins again from the first stage. The total time to reset is the tick period times the final stage number. A disable command is honoured only when the 16-bit key was written just before it, so a stray write cannot stop the watchdog. Once latched, the reset requests hold until the block itself is reset.

Top module: `wdg_top`

## Requirements
- R1: After reset every output is low, and the configuration, status and command-free read data are all zero.
- R2: Configuration at address 0x0 keeps bits [3:0] (source), 4 (periodic), 12 (interrupt enable), 13 (fast-interrupt enable), 14 (system-reset enable) and 15 (power-reset enable). All other bits read back as zero.
- R3: Writing 0xC45A to the low half of address 0xC arms the key, and any other value disarms it. Any write to the command address 0x8 consumes the key. A disable (command bit 1) without an armed key is ignored. When both command bits are set with an armed key, disable wins.
- R4: A start command (bit 0 at 0x8) sets running and clears the stage. Only pulses on tickIn[source] count, and only while running. A source value of NUM_SRC or above selects no input.
- R5: Each counted expiry adds one to the stage, which saturates at RST_STAGE. Status at 0x4 reads running in bit 0, pending in bit 1 and the stage in bits [5:4].
- R6: Each counted expiry sets pending. Writing 1 to status bit 1 clears it, and a simultaneous expiry wins. intOut equals pending AND the interrupt enable.
- R7: fiqOut is high while the stage is 2 or more and the fast-interrupt enable is set.
- R8: When the stage equals RST_STAGE, sysRstOut latches if bit 14 is set and pmcRstOut latches if bit 15 is set. Both hold through start and disable commands until the block is reset.
- R9: With the periodic bit clear, running drops after the first counted expiry, and later pulses change nothing.
- R10: An accepted disable clears running and the stage, so fiqOut falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low asynchronous reset |
| wrEn | input | 1 | register write strobe |
| addr | input | 4 | register byte address for write and read |
| wrData | input | 32 | write data |
| rdData | output | 32 | combinational read data at addr |
| tickIn | input | NUM_SRC | timer expiry pulses, one per source |
| intOut | output | 1 | interrupt |
| fiqOut | output | 1 | fast interrupt |
| sysRstOut | output | 1 | latched system reset request |
| pmcRstOut | output | 1 | latched power-controller reset request |

## Verification
The hardest state to reach from the ports is an armed key meeting a command write that is not a disable. That write must silently use up the key so that a disable right after it is refused. The directed part covers this case. It also covers a key overwritten by a wrong value and a one-shot watchdog that stops itself. A seeded random sequence then mixes ticks on every source value, including unselected and out-of-range sources, with keep-alives, pending clears and keyed disables. After each step it compares status and both interrupt lines with a bench model.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [3:0]  ADDR_CFG  = 4'h0;
  localparam logic [3:0]  ADDR_STAT = 4'h4;
  localparam logic [3:0]  ADDR_CMD  = 4'h8;
  localparam logic [3:0]  ADDR_KEY  = 4'hC;
  localparam logic [15:0] UNLOCK_KEY = 16'hC45A;
  localparam int FIQ_STAGE = 2;
  localparam int STAGE_LSB = 4;

  typedef struct packed {
    logic       pmcEn;
    logic       sysEn;
    logic       fiqEn;
    logic       intEn;
    logic       periodic;
    logic [3:0] src;
  } wdgCfg_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic clrPend;
  } wdgStrobe_t;
endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int STAGE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [3:0]         addr,
  input  logic [31:0]        wrData,
  input  logic               running,
  input  logic               pending,
  input  logic [STAGE_W-1:0] stage,
  output wdgCfg_t            cfg,
  output wdgStrobe_t         strobe,
  output logic [31:0]        rdData
);
  logic keyOk;
  logic cmdWr;
  logic keyWr;

  assign cmdWr = wrEn && (addr == ADDR_CMD);
  assign keyWr = wrEn && (addr == ADDR_KEY);

  always_comb begin
    strobe.stop    = cmdWr && wrData[1] && keyOk;
    strobe.start   = cmdWr && wrData[0] && !strobe.stop;
    strobe.clrPend = wrEn && (addr == ADDR_STAT) && wrData[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyOk <= 1'b0;
      cfg   <= '0;
    end else begin
      if (keyWr)      keyOk <= (wrData[15:0] == UNLOCK_KEY);
      else if (cmdWr) keyOk <= 1'b0;
      if (wrEn && (addr == ADDR_CFG)) begin
        cfg.src      <= wrData[3:0];
        cfg.periodic <= wrData[4];
        cfg.intEn    <= wrData[12];
        cfg.fiqEn    <= wrData[13];
        cfg.sysEn    <= wrData[14];
        cfg.pmcEn    <= wrData[15];
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CFG: begin
        rdData[3:0] = cfg.src;
        rdData[4]   = cfg.periodic;
        rdData[12]  = cfg.intEn;
        rdData[13]  = cfg.fiqEn;
        rdData[14]  = cfg.sysEn;
        rdData[15]  = cfg.pmcEn;
      end
      ADDR_STAT: begin
        rdData[0] = running;
        rdData[1] = pending;
        rdData[STAGE_LSB +: STAGE_W] = stage;
      end
      default: rdData = '0;
    endcase
  end

  // R3: a command write always leaves the key disarmed
  p_key_consumed_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr |=> !keyOk);
  // R3: the correct key arms
  p_key_arms_r3: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && wrData[15:0] == UNLOCK_KEY) |=> keyOk);
endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int RST_STAGE = 3,
  parameter int STAGE_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  wdgCfg_t            cfg,
  input  wdgStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] tickIn,
  output logic               running,
  output logic               pending,
  output logic [STAGE_W-1:0] stage,
  output logic               intOut,
  output logic               fiqOut,
  output logic               sysRstOut,
  output logic               pmcRstOut
);
  localparam logic [STAGE_W-1:0] STAGE_MAX = STAGE_W'(RST_STAGE);
  localparam logic [STAGE_W-1:0] STAGE_FIQ = STAGE_W'(FIQ_STAGE);

  logic [NUM_SRC-1:0] selVec;
  logic               tickSel;
  logic               countHit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_srcSel
    assign selVec[g] = tickIn[g] && (cfg.src == 4'(g));
  end

  assign tickSel  = |selVec;
  assign countHit = running && tickSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      stage   <= '0;
    end else if (strobe.stop) begin
      running <= 1'b0;
      stage   <= '0;
    end else if (strobe.start) begin
      running <= 1'b1;
      stage   <= '0;
    end else if (countHit) begin
      if (stage != STAGE_MAX) stage <= stage + 1'b1;
      if (!cfg.periodic) running <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pending <= 1'b0;
    else if (countHit)       pending <= 1'b1;
    else if (strobe.clrPend) pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysRstOut <= 1'b0;
      pmcRstOut <= 1'b0;
    end else if (stage == STAGE_MAX) begin
      if (cfg.sysEn) sysRstOut <= 1'b1;
      if (cfg.pmcEn) pmcRstOut <= 1'b1;
    end
  end

  assign intOut = pending && cfg.intEn;
  assign fiqOut = cfg.fiqEn && (stage >= STAGE_FIQ);

  // R5: stage never passes the final stage
  p_stage_sat_r5: assert property (@(posedge clk) disable iff (!rstN)
    stage <= STAGE_MAX);
  // R5: the stage moves only by one step up or back to zero
  p_stage_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stage != $past(stage)) |-> (stage == '0 || stage == STAGE_W'($past(stage) + 1'b1)));
  // R4: no stage change while stopped and no command arrives
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strobe.start && !strobe.stop) |=> $stable(stage));
  // R8: reset requests are sticky
  p_sys_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    sysRstOut |=> sysRstOut);
  p_pmc_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    pmcRstOut |=> pmcRstOut);
  // R6: a counted expiry leaves pending set
  p_pend_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    countHit |=> pending);
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int RST_STAGE = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [3:0]         addr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [NUM_SRC-1:0] tickIn,
  output logic               intOut,
  output logic               fiqOut,
  output logic               sysRstOut,
  output logic               pmcRstOut
);
  localparam int STAGE_W = $clog2(RST_STAGE + 1);

  wdgCfg_t            cfg;
  wdgStrobe_t         strobe;
  logic               running;
  logic               pending;
  logic [STAGE_W-1:0] stage;

  wdg_ctrl #(.STAGE_W(STAGE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .running(running), .pending(pending), .stage(stage),
    .cfg(cfg), .strobe(strobe), .rdData(rdData)
  );

  wdg_core #(.NUM_SRC(NUM_SRC), .RST_STAGE(RST_STAGE), .STAGE_W(STAGE_W)) i_core (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strobe(strobe), .tickIn(tickIn),
    .running(running), .pending(pending), .stage(stage),
    .intOut(intOut), .fiqOut(fiqOut), .sysRstOut(sysRstOut), .pmcRstOut(pmcRstOut)
  );
endmodule

// File: tb/test_wdg_top.sv
module test_wdg_top;
  localparam int NUM_SRC = 4;
  localparam int RST_STAGE = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [NUM_SRC-1:0] tickIn = '0;
  logic intOut, fiqOut, sysRstOut, pmcRstOut;

  int checks = 0;
  int fails = 0;

  // model state
  bit mRun, mPend, mPer, mIntEn, mFiqEn;
  int mStage, mSrc;

  always #10 clk = ~clk;

  wdg_top #(.NUM_SRC(NUM_SRC), .RST_STAGE(RST_STAGE)) i_wdg_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .tickIn(tickIn), .intOut(intOut), .fiqOut(fiqOut),
    .sysRstOut(sysRstOut), .pmcRstOut(pmcRstOut)
  );

  function automatic logic [31:0] statVal(bit run, bit pend, int stg);
    return (32'(stg) << 4) | (32'(pend) << 1) | 32'(run);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(string req, logic [3:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdData, exp);
  endtask

  task automatic pulse(int s);
    @(negedge clk);
    tickIn = '0;
    if (s < NUM_SRC) tickIn[s] = 1'b1;
    @(negedge clk);
    tickIn = '0;
  endtask

  task automatic modelPulse(int s);
    if (mRun && s == mSrc && s < NUM_SRC) begin
      if (mStage < RST_STAGE) mStage++;
      mPend = 1'b1;
      if (!mPer) mRun = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", {28'd0, intOut, fiqOut, sysRstOut, pmcRstOut}, 32'd0);
    rdChk("R1 cfg", 4'h0, 32'd0);
    rdChk("R1 status", 4'h4, 32'd0);

    // R2 config readback
    wr(4'h0, 32'hFFFF_FFFF);
    rdChk("R2 cfg mask", 4'h0, 32'h0000_F01F);
    wr(4'h0, 32'h0000_3011); // src1, periodic, int+fiq enabled
    rdChk("R2 cfg value", 4'h0, 32'h0000_3011);

    // R4 start and source selection
    wr(4'h8, 32'h1);
    rdChk("R4 started", 4'h4, statVal(1, 0, 0));
    pulse(0);
    pulse(2);
    rdChk("R4 unselected ignored", 4'h4, statVal(1, 0, 0));
    pulse(1);
    rdChk("R5 stage1", 4'h4, statVal(1, 1, 1));
    chk("R6 intOut", intOut, 1'b1);
    chk("R7 fiq low at 1", fiqOut, 1'b0);
    // R6 W1C
    wr(4'h4, 32'h2);
    chk("R6 cleared", intOut, 1'b0);
    pulse(1);
    chk("R7 fiq at 2", fiqOut, 1'b1);
    rdChk("R5 stage2", 4'h4, statVal(1, 1, 2));

    // R3 disable without key ignored
    wr(4'h8, 32'h2);
    rdChk("R3 no key ignored", 4'h4, statVal(1, 1, 2));
    // R3 wrong key disarms
    wr(4'hC, 32'h0000_C45A);
    wr(4'hC, 32'h0000_1234);
    wr(4'h8, 32'h2);
    rdChk("R3 wrong key ignored", 4'h4, statVal(1, 1, 2));
    // R3 key consumed by a start command (also keep-alive, R4)
    wr(4'hC, 32'h0000_C45A);
    wr(4'h8, 32'h1);
    rdChk("R4 keepalive", 4'h4, statVal(1, 1, 0));
    chk("R7 fiq drops on keepalive", fiqOut, 1'b0);
    wr(4'h8, 32'h2);
    rdChk("R3 key consumed", 4'h4, statVal(1, 1, 0));
    // R10 keyed disable
    pulse(1); pulse(1);
    chk("R7 fiq before disable", fiqOut, 1'b1);
    wr(4'hC, 32'h0000_C45A);
    wr(4'h8, 32'h3);
    rdChk("R10 disabled", 4'h4, statVal(0, 1, 0));
    chk("R10 fiq falls", fiqOut, 1'b0);
    pulse(1);
    rdChk("R4 stopped ignores ticks", 4'h4, statVal(0, 1, 0));

    // R4 out-of-range source
    wr(4'h4, 32'h2);
    wr(4'h0, 32'h0000_3014);
    wr(4'h8, 32'h1);
    for (int s = 0; s < NUM_SRC; s++) pulse(s);
    rdChk("R4 src out of range", 4'h4, statVal(1, 0, 0));

    // R9 one-shot
    wr(4'h0, 32'h0000_3002);
    wr(4'h8, 32'h1);
    pulse(2);
    rdChk("R9 one-shot stops", 4'h4, statVal(0, 1, 1));
    pulse(2);
    rdChk("R9 later ignored", 4'h4, statVal(0, 1, 1));

    // random phase, resets disabled
    mRun = 0; mPend = 1; mStage = 1;
    for (int it = 0; it < 400; it++) begin
      int op;
      if (it % 50 == 0) begin
        mSrc = int'($urandom % 5);
        mPer = ($urandom % 4) != 0;
        mIntEn = $urandom % 2;
        mFiqEn = $urandom % 2;
        wr(4'h0, (32'(mFiqEn) << 13) | (32'(mIntEn) << 12) | (32'(mPer) << 4) | 32'(mSrc));
      end
      op = int'($urandom % 7);
      if (op <= 2) begin
        int s;
        s = int'($urandom % 5);
        pulse(s);
        modelPulse(s);
      end else if (op == 3) begin
        wr(4'h8, 32'h1);
        mRun = 1; mStage = 0;
      end else if (op == 4) begin
        wr(4'h4, 32'h2);
        mPend = 0;
      end else if (op == 5) begin
        wr(4'hC, 32'h0000_C45A);
        wr(4'h8, 32'h2);
        mRun = 0; mStage = 0;
      end else begin
        wr(4'h8, 32'h2); // unkeyed disable, ignored
      end
      rdChk("R5 random status", 4'h4, statVal(mRun, mPend, mStage));
      chk("R6 random intOut", intOut, mPend & mIntEn);
      chk("R7 random fiqOut", fiqOut, mFiqEn && mStage >= 2);
      chk("R8 random no reset", {sysRstOut, pmcRstOut}, 2'b00);
    end

    // R8 reset escalation
    wr(4'h0, 32'h0000_4010); // src0, periodic, system reset only
    wr(4'h8, 32'h1);
    pulse(0); pulse(0);
    @(negedge clk);
    chk("R8 no reset at stage2", {sysRstOut, pmcRstOut}, 2'b00);
    pulse(0);
    @(negedge clk);
    chk("R8 sys latched", {sysRstOut, pmcRstOut}, 2'b10);
    wr(4'h0, 32'h0000_C010);
    @(negedge clk);
    chk("R8 pmc latched at final stage", {sysRstOut, pmcRstOut}, 2'b11);
    pulse(0);
    rdChk("R5 saturates", 4'h4, statVal(1, 1, 3));
    wr(4'h8, 32'h1);
    wr(4'hC, 32'h0000_C45A);
    wr(4'h8, 32'h2);
    chk("R8 held through commands", {sysRstOut, pmcRstOut}, 2'b11);
    rstN = 1'b0;
    #1;
    chk("R1 reset clears latches", {sysRstOut, pmcRstOut}, 2'b00);
    @(negedge clk);
    rstN = 1'b1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule